// File: doc/BRIEF.md
# Triplicated Dual-Port Memory with Background Scrub

This block stores every data word three times, once in each of three true dual-port RAMs, so that a single upset in any one copy cannot corrupt what the user sees. The first port of every RAM belongs to the user. A write lands in all three copies at once. A read returns the bitwise two-of-three majority of the copies one cycle later.

The second port of every RAM is owned by a scrub engine that walks the address space without pause. At each address it reads the three copies in one cycle. In the next cycle it writes the voted word back into any copy that disagrees with it. Periodic re-reading and rewriting like this keeps upsets in different copies from piling up at the same address until the vote can no longer recover the word. The user port is never held off by the scrub.

If the user writes the address under repair between the scrub read and the scrub write, that write-back is dropped so that stale data cannot land. A saturating counter records how many scrub steps made a repair. The current scrub address is also visible at the ports.

Top module: `tmr_scrub_mem`

## Requirements
- R1: A user write (userEn=1, userWe=1) stores userWdata at userAddr in all three copies on the same clock edge. A later flip of bits in any single copy at that address does not change the value read back.
- R2: A user read (userEn=1, userWe=0) presents the bitwise two-of-three majority of the three copies at userAddr on userRdata one clock edge after the command. The value holds until the next read.
- R3: The user port accepts a read or a write on every cycle, whatever the scrub engine is doing.
- R4: Each scrub step lasts two cycles: a read of all copies, then a write-back. scrubAddr is 0 after reset and holds its value through both cycles of a step. It then advances by one and wraps from DEPTH-1 to 0.
- R5: In the write-back cycle, every copy whose word differs from the majority is overwritten with the majority. A later single-copy upset at that address in another copy still reads back correctly.
- R6: corrCount is 0 after reset. It increases by exactly one for each scrub step that rewrote at least one copy, however many copies that step rewrote.
- R7: corrCount saturates at 2^CNT_W-1 and stays there.
- R8: If a user write targets the current scrub address in either cycle of a scrub step, that step's write-back is cancelled and does not count as a correction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of scrub state and counter (memory contents are kept) |
| userEn | input | 1 | User command valid |
| userWe | input | 1 | 1 = write, 0 = read, when userEn is high |
| userAddr | input | ADDR_W | User word address |
| userWdata | input | DATA_W | User write data |
| userRdata | output | DATA_W | Majority-voted read data, one cycle after a read |
| scrubAddr | output | ADDR_W | Address of the scrub step in progress |
| corrCount | output | CNT_W | Saturating count of scrub steps that repaired a copy |

## Verification
A corrupted copy that the scrub fails to repair stays invisible on userRdata until a second upset hits a different copy at the same address. The bench therefore injects a second upset after one full scrub pass (2*DEPTH cycles) and reads the word back. A wrong count or a missed cancellation shows up on corrCount within one step, two cycles. A broken address sequence shows on scrubAddr within two cycles. A faulty voter or copy write shows on the first read after a single-copy upset, one cycle after the read command.

// File: rtl/tmr_scrub_pkg.sv
package tmr_scrub_pkg;
  localparam int unsigned COPIES = 3;

  // strobes from scrub control to datapath
  typedef struct packed {
    logic scrubRead;   // port B reads all copies at scrubAddr
    logic scrubWrite;  // port B may write back voted word
  } scrubStrobe_t;
endpackage

// File: rtl/tmr_dpram.sv
module tmr_dpram #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 32,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              aEn,
  input  logic              aWe,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [DATA_W-1:0] aWdata,
  output logic [DATA_W-1:0] aRdata,
  input  logic              bRe,
  input  logic              bWe,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic [DATA_W-1:0] bWdata,
  output logic [DATA_W-1:0] bRdata
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] aQ;
  logic [DATA_W-1:0] bQ;

  always_ff @(posedge clk) begin
    if (aEn) begin
      if (aWe) mem[aAddr] <= aWdata;
      else     aQ <= mem[aAddr];
    end
    if (bRe) bQ <= mem[bAddr];
    if (bWe) mem[bAddr] <= bWdata;
  end

  assign aRdata = aQ;
  assign bRdata = bQ;
endmodule

// File: rtl/tmr_scrub_datapath.sv
module tmr_scrub_datapath
  import tmr_scrub_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 32,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              userEn,
  input  logic              userWe,
  input  logic [ADDR_W-1:0] userAddr,
  input  logic [DATA_W-1:0] userWdata,
  output logic [DATA_W-1:0] userRdata,
  input  scrubStrobe_t      strobe,
  input  logic [ADDR_W-1:0] scrubAddr,
  output logic              needFix
);
  logic [DATA_W-1:0] userQ  [COPIES];
  logic [DATA_W-1:0] scrubQ [COPIES];
  logic [DATA_W-1:0] scrubVote;
  logic [COPIES-1:0] diffMask;
  logic [COPIES-1:0] wrMask;

  for (genvar i = 0; i < COPIES; i++) begin : gen_copy
    tmr_dpram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
      .clk    (clk),
      .aEn    (userEn),
      .aWe    (userWe),
      .aAddr  (userAddr),
      .aWdata (userWdata),
      .aRdata (userQ[i]),
      .bRe    (strobe.scrubRead),
      .bWe    (wrMask[i]),
      .bAddr  (scrubAddr),
      .bWdata (scrubVote),
      .bRdata (scrubQ[i])
    );
    assign diffMask[i] = (scrubQ[i] != scrubVote);
    assign wrMask[i]   = diffMask[i] & strobe.scrubWrite;
  end

  // bitwise two-of-three majority on both ports
  assign userRdata = (userQ[0] & userQ[1]) | (userQ[0] & userQ[2]) | (userQ[1] & userQ[2]);
  assign scrubVote = (scrubQ[0] & scrubQ[1]) | (scrubQ[0] & scrubQ[2]) | (scrubQ[1] & scrubQ[2]);
  assign needFix   = |diffMask;

  // R8
  no_collide_chk: assert property (@(posedge clk) disable iff (rst)
    (userEn && userWe && (|wrMask)) |-> (userAddr != scrubAddr));
endmodule

// File: rtl/tmr_scrub_ctrl.sv
module tmr_scrub_ctrl
  import tmr_scrub_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned CNT_W = 8,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              userEn,
  input  logic              userWe,
  input  logic [ADDR_W-1:0] userAddr,
  input  logic              needFix,
  output scrubStrobe_t      strobe,
  output logic [ADDR_W-1:0] scrubAddr,
  output logic [CNT_W-1:0]  corrCount
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0]  CNT_MAX   = '1;

  logic phaseWr;
  logic hitPending;
  logic userHit;
  logic cancel;

  assign userHit = userEn & userWe & (userAddr == scrubAddr);
  assign cancel  = hitPending | userHit;

  assign strobe.scrubRead  = ~phaseWr;
  assign strobe.scrubWrite = phaseWr & ~cancel;

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseWr    <= 1'b0;
      hitPending <= 1'b0;
      scrubAddr  <= '0;
      corrCount  <= '0;
    end else begin
      phaseWr <= ~phaseWr;
      if (!phaseWr) begin
        hitPending <= userHit;
      end else begin
        hitPending <= 1'b0;
        scrubAddr  <= (scrubAddr == LAST_ADDR) ? '0 : scrubAddr + 1'b1;
        if (strobe.scrubWrite && needFix && corrCount != CNT_MAX)
          corrCount <= corrCount + 1'b1;
      end
    end
  end

  // R4
  phase_alternate_chk: assert property (@(posedge clk) disable iff (rst)
    phaseWr |=> !phaseWr);
  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !phaseWr |=> $stable(scrubAddr));
  // R6
  count_only_after_step_chk: assert property (@(posedge clk) disable iff (rst)
    !phaseWr |=> $stable(corrCount));
  // R7
  count_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (&corrCount) |=> (&corrCount));
endmodule

// File: rtl/tmr_scrub_mem.sv
module tmr_scrub_mem
  import tmr_scrub_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned CNT_W  = 8,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              userEn,
  input  logic              userWe,
  input  logic [ADDR_W-1:0] userAddr,
  input  logic [DATA_W-1:0] userWdata,
  output logic [DATA_W-1:0] userRdata,
  output logic [ADDR_W-1:0] scrubAddr,
  output logic [CNT_W-1:0]  corrCount
);
  scrubStrobe_t strobe;
  logic         needFix;

  tmr_scrub_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .userEn    (userEn),
    .userWe    (userWe),
    .userAddr  (userAddr),
    .needFix   (needFix),
    .strobe    (strobe),
    .scrubAddr (scrubAddr),
    .corrCount (corrCount)
  );

  tmr_scrub_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .userEn    (userEn),
    .userWe    (userWe),
    .userAddr  (userAddr),
    .userWdata (userWdata),
    .userRdata (userRdata),
    .strobe    (strobe),
    .scrubAddr (scrubAddr),
    .needFix   (needFix)
  );
endmodule

// File: tb/tmr_scrub_mem_tb.sv
module tmr_scrub_mem_tb;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 32;
  localparam int CNT_W  = 8;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int CNT_MAX = (1 << CNT_W) - 1;
  localparam int PASS_CYC = 2 * DEPTH;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              userEn = 1'b0;
  logic              userWe = 1'b0;
  logic [ADDR_W-1:0] userAddr = '0;
  logic [DATA_W-1:0] userWdata = '0;
  logic [DATA_W-1:0] userRdata;
  logic [ADDR_W-1:0] scrubAddr;
  logic [CNT_W-1:0]  corrCount;

  tmr_scrub_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .userEn(userEn), .userWe(userWe), .userAddr(userAddr),
    .userWdata(userWdata), .userRdata(userRdata), .scrubAddr(scrubAddr),
    .corrCount(corrCount)
  );

  always #10 clk = ~clk;  // 50 MHz

  logic [DATA_W-1:0] model [DEPTH];
  int checks = 0;
  int errors = 0;
  int expCnt = 0;
  bit finished = 0;

  function automatic int satAdd(int cur, int inc);
    return (cur + inc > CNT_MAX) ? CNT_MAX : cur + inc;
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic userWrite(int a, logic [DATA_W-1:0] d);
    userEn = 1'b1; userWe = 1'b1; userAddr = ADDR_W'(a); userWdata = d;
    @(negedge clk);
    userEn = 1'b0; userWe = 1'b0;
    model[a] = d;
  endtask

  task automatic userRead(int a, string req);
    userEn = 1'b1; userWe = 1'b0; userAddr = ADDR_W'(a);
    @(negedge clk);
    userEn = 1'b0;
    check(req, userRdata, model[a]);
  endtask

  task automatic upset(int copy, int a, logic [DATA_W-1:0] mask);
    case (copy)
      0: u_dut.u_dp.gen_copy[0].u_ram.mem[a] = u_dut.u_dp.gen_copy[0].u_ram.mem[a] ^ mask;
      1: u_dut.u_dp.gen_copy[1].u_ram.mem[a] = u_dut.u_dp.gen_copy[1].u_ram.mem[a] ^ mask;
      default: u_dut.u_dp.gen_copy[2].u_ram.mem[a] = u_dut.u_dp.gen_copy[2].u_ram.mem[a] ^ mask;
    endcase
  endtask

  // returns at the negedge of the read cycle of the step at address a
  task automatic waitScrubAt(int a);
    logic [ADDR_W-1:0] prev;
    do begin
      prev = scrubAddr;
      @(negedge clk);
    end while (!(scrubAddr == ADDR_W'(a) && prev != ADDR_W'(a)));
  endtask

  task automatic waitCycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [DATA_W-1:0] oneBit();
    return DATA_W'(1) << ($urandom % DATA_W);
  endfunction

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    // fill memory while scrub state is held in reset
    for (int a = 0; a < DEPTH; a++) userWrite(a, DATA_W'($urandom));
    waitCycles(2);
    rst = 1'b0;
    // R4 R6: reset state
    check("R4 reset scrubAddr", scrubAddr, 0);
    check("R6 reset corrCount", corrCount, 0);

    // R1 R2 R3: random user traffic during scrubbing
    for (int n = 0; n < 400; n++) begin
      int a;
      a = $urandom % DEPTH;
      if ($urandom % 2) userWrite(a, DATA_W'($urandom));
      else userRead(a, "R2 random read");
    end
    // R3: back-to-back commands every cycle
    for (int n = 0; n < 8; n++) begin
      userEn = 1'b1; userWe = 1'b1; userAddr = ADDR_W'(n); userWdata = DATA_W'(16'hA500 + n);
      model[n] = userWdata;
      @(negedge clk);
    end
    for (int n = 0; n < 8; n++) begin
      userEn = 1'b1; userWe = 1'b0; userAddr = ADDR_W'(n);
      @(negedge clk);
      check("R3 back-to-back read", userRdata, model[n]);
    end
    userEn = 1'b0;
    check("R6 no spurious correction", corrCount, expCnt);

    // R1 R2: single-copy upset is voted out on read
    upset(1, 7, oneBit());
    userRead(7, "R1 vote hides one upset");
    waitCycles(PASS_CYC + 2);
    expCnt = satAdd(expCnt, 1);
    check("R6 one repair counted", corrCount, expCnt);
    // R5: upset in another copy after repair still votes correctly
    upset(2, 7, DATA_W'(16'hFFFF));
    userRead(7, "R5 repair restored copy");
    waitCycles(PASS_CYC + 2);
    expCnt = satAdd(expCnt, 1);
    check("R6 second repair counted", corrCount, expCnt);

    // R6: two copies wrong in different bits at one address -> +1
    upset(0, 12, DATA_W'(16'h0001));
    upset(2, 12, DATA_W'(16'h0100));
    userRead(12, "R2 bitwise vote");
    waitCycles(PASS_CYC + 2);
    expCnt = satAdd(expCnt, 1);
    check("R6 one count per step", corrCount, expCnt);
    userRead(12, "R5 both copies repaired");

    // R8: user write in read cycle of the step cancels write-back
    upset(2, 20, DATA_W'(16'h0040));
    waitScrubAt(20);
    userEn = 1'b1; userWe = 1'b1; userAddr = ADDR_W'(20); userWdata = 16'h1234;
    model[20] = 16'h1234;
    @(negedge clk);
    userEn = 1'b0; userWe = 1'b0;
    waitCycles(2);
    check("R8 cancel in read cycle", corrCount, expCnt);
    userRead(20, "R8 user data kept");
    waitCycles(PASS_CYC + 2);
    check("R8 no later correction", corrCount, expCnt);

    // R8: user write in write-back cycle cancels write-back
    upset(0, 25, DATA_W'(16'h8000));
    waitScrubAt(25);
    @(negedge clk);
    userEn = 1'b1; userWe = 1'b1; userAddr = ADDR_W'(25); userWdata = 16'hBEEF;
    model[25] = 16'hBEEF;
    @(negedge clk);
    userEn = 1'b0; userWe = 1'b0;
    @(negedge clk);
    check("R8 cancel in write cycle", corrCount, expCnt);
    userRead(25, "R8 write-cycle data kept");
    waitCycles(PASS_CYC + 2);
    check("R8 no later correction wr", corrCount, expCnt);

    // R4: address holds two cycles, steps by one, wraps
    waitScrubAt(5);
    @(negedge clk);
    check("R4 addr holds", scrubAddr, 5);
    @(negedge clk);
    check("R4 addr steps", scrubAddr, 6);
    waitScrubAt(DEPTH - 1);
    waitCycles(2);
    check("R4 addr wraps", scrubAddr, 0);

    // R6 R7: full-pass upsets until saturation
    for (int p = 0; p < 9; p++) begin
      waitScrubAt(0);
      for (int a = 0; a < DEPTH; a++) upset(a % 3, a, oneBit());
      waitCycles(PASS_CYC);
      expCnt = satAdd(expCnt, DEPTH);
      check("R7 count per pass saturating", corrCount, expCnt);
    end
    check("R7 saturated value", corrCount, CNT_MAX);
    for (int a = 0; a < DEPTH; a += 9) userRead(a, "R5 data after mass repair");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule